// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synthesizable model of a single-ported synchronous burst SRAM whose data words are split into byte lanes. The parity bits of each lane are carried inside the lane. On every rising clock edge the block samples:

- three chip enables;
- two address strobes, one for the processor side and one for the controller side;
- an advance input;
- a global write input, a byte-write enable and one select per lane.

From these inputs it decides which kind of cycle is running: power-down, deselect, burst start, burst continue or burst suspend. It then reads or writes the selected lanes of the addressed word.

A burst starts at the external address. Each later cycle with advance asserted moves to the next word in a linear, four-beat wrapping sequence, and only the two address LSBs change. A cycle with advance released keeps the current word. A start from the processor-side strobe is always a read. A write can only follow such a start on a later clock, or be started by the controller-side strobe.

Read data is registered and appears on `dq_out` one clock after the cycle that read it. A separate drive indication, `dq_drive`, stands in for a tri-state buffer. It is gated without a clock by the output enable, and it is forced off during a write cycle, during sleep, and after a deselect.

Top module: `sbs_burst_sram`

## Requirements
- R1: The lane write mask is decoded as follows. If `gw_n` is low, all lanes are written. Otherwise, if `bwe_n` is low, each lane whose `bsel_n` bit is low is written (bit 0 is lane 0, `dq` bits 8:0; bit 1 is lane 1, bits 17:9). Otherwise nothing is written, and a cycle with an empty mask is a read.
- R2: A start by `adsp_n` low, with `ce1_n` low and the device selected, is always a read of the external address, whatever `gw_n`, `bwe_n` and `bsel_n` are. A write presented on the following clock goes to that same address.
- R3: A start by `adsc_n` low, with the device selected and `adsp_n` not taking effect, uses the external address. It writes the masked lanes when a write is requested, and reads otherwise.
- R4: A cycle with no effective strobe and `adv_n` low, inside an active burst, accesses the next address. The two address LSBs increment modulo 4 and the upper bits are unchanged.
- R5: A cycle with no effective strobe and `adv_n` high, inside an active burst, accesses the current address again.
- R6: Read data appears on `dq_out` in the cycle after the read cycle. A write commits at the clock edge of its own cycle, so a read one cycle later returns the new data.
- R7: `oe_n` acts without a clock: while read data is pending, `dq_drive` follows `oe_n` low in the same cycle, and `oe_n` high forces `dq_drive` low.
- R8: During a write cycle `dq_drive` is low, even with `oe_n` low and read data pending.
- R9: While `sleep` is high, both strobes and all write inputs are ignored and `dq_drive` is low in that cycle and in the next.
- R10: A strobe while the enables do not select the device is a deselect. The device is selected only when `ce1_n` is low, `ce2` is high and `ce3_n` is low. After a deselect, `dq_drive` is low in the next cycle, and continue or suspend cycles neither read nor write until a new start.
- R11: After synchronous reset, `dq_drive` is low and `dq_out` is zero.
- R12: Whenever `dq_drive` is low, `dq_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Power-down request |
| ce1_n | input | 1 | Chip enable, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | External word address |
| oe_n | input | 1 | Output enable, active low, not clocked |
| wdata | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Registered read data, zero when not driven |
| dq_drive | output | 1 | Output driver enable |

## Verification
The clash this block must resolve is a processor-side start that arrives with every write input asserted. In that one cycle the read rule and the write decode both apply, and the read must win. The bench does this on every address of the array, with all write inputs low and junk on the data inputs. It judges the result by the data returned one clock later and by a later read-back that finds memory unchanged. A second clash is a write on the clock right after that start while read data is still pending with `oe_n` low. The bench samples `dq_drive` inside that write cycle to check that the write masks the output, then reads the word back to confirm that only the selected lane changed.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Width of the wrapping burst counter (four beats).
    parameter int unsigned BURST_W = 2;

    typedef enum logic [2:0] {
        CK_NOP   = 3'd0,   // no strobe and no active burst
        CK_SLEEP = 3'd1,   // power-down
        CK_DESEL = 3'd2,   // strobe with the device not selected
        CK_START = 3'd3,   // burst start at the external address
        CK_NEXT  = 3'd4,   // burst continue at the next address
        CK_HOLD  = 3'd5    // burst suspend at the current address
    } cyc_kind_e;

    function automatic logic [BURST_W-1:0] burst_step(input logic [BURST_W-1:0] cnt);
        return cnt + BURST_W'(1);
    endfunction

    function automatic logic is_access(input cyc_kind_e k);
        return (k == CK_START) || (k == CK_NEXT) || (k == CK_HOLD);
    endfunction

endpackage

// File: rtl/sbs_cycle_dec.sv
module sbs_cycle_dec
    import sbs_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic             sleep,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             active,
    output cyc_kind_e        kind,
    output logic             do_write,
    output logic             do_read,
    output logic [LANES-1:0] lane_we
);
    logic             selected;
    logic             p_strobe;
    logic             any_strobe;
    logic [LANES-1:0] mask;
    logic             wr_req;

    always_comb begin
        selected   = !ce1_n && ce2 && !ce3_n;
        p_strobe   = !adsp_n && !ce1_n;
        any_strobe = p_strobe || !adsc_n;

        if (!gw_n)       mask = '1;
        else if (!bwe_n) mask = ~bsel_n;
        else             mask = '0;
        wr_req = |mask;

        if (sleep)           kind = CK_SLEEP;
        else if (any_strobe) kind = selected ? CK_START : CK_DESEL;
        else if (!active)    kind = CK_NOP;
        else if (!adv_n)     kind = CK_NEXT;
        else                 kind = CK_HOLD;

        // A processor-strobe start is always a read.
        do_write = wr_req && ((kind == CK_START && !p_strobe)
                              || kind == CK_NEXT || kind == CK_HOLD);
        do_read  = is_access(kind) && !do_write;
        lane_we  = do_write ? mask : '0;
    end
endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_kind_e         kind,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              active
);
    localparam int unsigned BW = BURST_W;

    logic [ADDR_W-1:0] addr_q;
    logic              active_q;

    always_comb begin
        case (kind)
            CK_START: acc_addr = ext_addr;
            CK_NEXT:  acc_addr = {addr_q[ADDR_W-1:BW], burst_step(addr_q[BW-1:0])};
            default:  acc_addr = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            active_q <= 1'b0;
        end else begin
            case (kind)
                CK_START: begin
                    addr_q   <= ext_addr;
                    active_q <= 1'b1;
                end
                CK_NEXT:  addr_q   <= acc_addr;
                CK_DESEL: active_q <= 1'b0;
                default:  ;
            endcase
        end
    end

    assign active = active_q;
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_vld
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_lane;

        always_ff @(posedge clk) begin
            if (lane_we[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)      rd_lane     <= store[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_lane;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld <= 1'b0;
        else     rd_vld <= rd_en;
    end
endmodule

// File: rtl/sbs_burst_sram.sv
module sbs_burst_sram
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sleep,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bsel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    cyc_kind_e         kind;
    logic              do_write;
    logic              do_read;
    logic [LANES-1:0]  lane_we;
    logic              active;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] rd_q;
    logic              rd_vld;

    sbs_cycle_dec #(.LANES(LANES)) i_dec (
        .sleep    (sleep),
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .adv_n    (adv_n),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bsel_n   (bsel_n),
        .active   (active),
        .kind     (kind),
        .do_write (do_write),
        .do_read  (do_read),
        .lane_we  (lane_we)
    );

    sbs_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .ext_addr (addr),
        .acc_addr (acc_addr),
        .active   (active)
    );

    sbs_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (do_read),
        .lane_we (lane_we),
        .addr    (acc_addr),
        .wdata   (wdata),
        .rdata   (rd_q),
        .rd_vld  (rd_vld)
    );

    // Output gating is combinational: output enable, write mask and sleep.
    always_comb begin
        dq_drive = rd_vld && !oe_n && !do_write && !sleep;
        dq_out   = dq_drive ? rd_q : '0;
    end
endmodule

// File: rtl/sbs_burst_sram_chk.sv
module sbs_burst_sram_chk
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              oe_n,
    input logic              dq_drive,
    input logic [DATA_W-1:0] dq_out,
    input logic              do_write,
    input logic              rd_vld,
    input cyc_kind_e         kind,
    input logic [ADDR_W-1:0] acc_addr
);
    logic sel_c;
    logic pstart_c;
    logic strobe_c;

    assign sel_c    = !ce1_n && ce2 && !ce3_n;
    assign pstart_c = !sleep && !adsp_n && sel_c;
    assign strobe_c = !adsc_n || (!adsp_n && !ce1_n);

    p_adsp_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        pstart_c |-> !do_write);

    p_adsp_reads_r2: assert property (@(posedge clk) disable iff (rst)
        pstart_c |=> rd_vld);

    p_burst_step_r4: assert property (@(posedge clk) disable iff (rst)
        (kind == CK_NEXT && is_access($past(kind)))
        |-> (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1)
            && (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

    p_suspend_same_r5: assert property (@(posedge clk) disable iff (rst)
        (kind == CK_HOLD && is_access($past(kind))) |-> acc_addr == $past(acc_addr));

    p_oe_gates_r7: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_drive);

    p_write_masks_r8: assert property (@(posedge clk) disable iff (rst)
        do_write |-> !dq_drive);

    p_sleep_dark_r9: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_drive && !do_write);

    p_sleep_after_r9: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !dq_drive);

    p_desel_dark_r10: assert property (@(posedge clk) disable iff (rst)
        (!sleep && strobe_c && !sel_c) |=> !rd_vld);

    p_zero_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !dq_drive |-> dq_out == '0);
endmodule

bind sbs_burst_sram sbs_burst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .oe_n     (oe_n),
    .dq_drive (dq_drive),
    .dq_out   (dq_out),
    .do_write (do_write),
    .rd_vld   (rd_vld),
    .kind     (kind),
    .acc_addr (acc_addr)
);

// File: tb/test_sbs_burst_sram.sv
`timescale 1ns/1ps
module test_sbs_burst_sram;
    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          sleep, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
    logic [1:0]    bsel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] dq_out;
    logic          dq_drive;

    logic [DW-1:0] ref_mem [64];
    int            n_chk = 0;
    int            n_err = 0;
    bit            done  = 1'b0;

    always #10 clk = ~clk;

    sbs_burst_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) i_sbs_burst_sram (
        .clk(clk), .rst(rst), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .addr(addr), .oe_n(oe_n), .wdata(wdata),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    function automatic logic [DW-1:0] pat(int a, int seed);
        return DW'((a * 2731 + seed * 977 + 5) & 32'h3ffff);
    endfunction

    function automatic logic [1:0] lanes_of(logic gw, logic bwe, logic [1:0] bs);
        if (!gw)  return 2'b11;
        if (!bwe) return ~bs;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [1:0] m);
        logic [DW-1:0] r = old;
        if (m[0]) r[8:0]  = d[8:0];
        if (m[1]) r[17:9] = d[17:9];
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic set_idle();
        sleep = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 2'b11;
        oe_n = 1'b0; addr = '0; wdata = '0;
    endtask

    // Controller-strobe start; updates the reference with the decoded lanes.
    task automatic wr_adsc(int a, logic [DW-1:0] d, logic gw, logic bwe, logic [1:0] bs);
        adsc_n = 1'b0; addr = AW'(a); wdata = d;
        gw_n = gw; bwe_n = bwe; bsel_n = bs;
        tick();
        ref_mem[a] = merge(ref_mem[a], d, lanes_of(gw, bwe, bs));
        set_idle();
    endtask

    // Processor-strobe start with every write input asserted: must read.
    task automatic rd_adsp(int a, string tag);
        adsp_n = 1'b0; addr = AW'(a);
        gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 2'b00; wdata = ~pat(a, 99);
        tick();
        set_idle();
        #1;
        chk({tag, " drive"}, 32'(dq_drive), 32'd1);
        chk({tag, " data"}, 32'(dq_out), 32'(ref_mem[a]));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        set_idle();
        rst = 1'b1;
        tick(); tick();
        #1;
        chk("R11 drive at reset", 32'(dq_drive), 32'd0);
        chk("R11 R12 data at reset", 32'(dq_out), 32'd0);
        rst = 1'b0;

        // R3: fill every word by controller-strobe full writes.
        for (int a = 0; a < 64; a++) wr_adsc(a, pat(a, 1), 1'b0, 1'b1, 2'b11);

        // R2: processor-strobe starts read everything; memory must stay unchanged.
        for (int a = 0; a < 64; a++) rd_adsp(a, "R2 adsp read");
        for (int a = 0; a < 64; a += 7) rd_adsp(a, "R2 no write leaked");

        // R4: four-beat wrapping bursts from every start address.
        for (int s = 0; s < 64; s++) begin
            rd_adsp(s, "R4 burst first");
            for (int k = 1; k < 4; k++) begin
                adv_n = 1'b0;
                tick();
                set_idle();
                #1;
                chk("R4 burst beat", 32'(dq_out), 32'(ref_mem[(s & 60) | ((s + k) & 3)]));
            end
        end

        // R5: continue, suspend, suspend, continue.
        rd_adsp(22, "R5 start");
        adv_n = 1'b0; tick(); set_idle(); #1;
        chk("R5 advance", 32'(dq_out), 32'(ref_mem[23]));
        tick(); #1;
        chk("R5 suspend 1", 32'(dq_out), 32'(ref_mem[23]));
        tick(); #1;
        chk("R5 suspend 2", 32'(dq_out), 32'(ref_mem[23]));
        adv_n = 1'b0; tick(); set_idle(); #1;
        chk("R5 wrap after suspend", 32'(dq_out), 32'(ref_mem[20]));

        // R1: sweep global write, byte-write enable and both selects.
        for (int c = 0; c < 16; c++) begin
            wr_adsc(40 + c, pat(c, 7), c[3], c[2], 2'(c));
            tick(); #1;
            chk("R1 lane decode", 32'(dq_out), 32'(ref_mem[40 + c]));
        end

        // R6: write then read one cycle later.
        wr_adsc(30, pat(30, 55), 1'b0, 1'b1, 2'b11);
        #1;
        chk("R6 no drive after write", 32'(dq_drive), 32'd0);
        tick(); #1;
        chk("R6 read after write", 32'(dq_out), 32'(pat(30, 55)));
        rd_adsp(30, "R6 readback");

        // R8 / R2: write on the clock after a processor-strobe start.
        adsp_n = 1'b0; addr = 6'd20; gw_n = 1'b0; bwe_n = 1'b0; bsel_n = 2'b00;
        tick();
        set_idle();
        bwe_n = 1'b0; bsel_n = 2'b10; wdata = pat(20, 33);
        #1;
        chk("R8 masked during write", 32'(dq_drive), 32'd0);
        chk("R8 R12 zero data", 32'(dq_out), 32'd0);
        tick();
        ref_mem[20] = merge(ref_mem[20], pat(20, 33), 2'b01);
        set_idle();
        rd_adsp(20, "R2 write after adsp lane0");

        // R7: output enable acts without a clock.
        rd_adsp(12, "R7 read");
        oe_n = 1'b1; #1;
        chk("R7 oe high", 32'(dq_drive), 32'd0);
        chk("R12 zero when off", 32'(dq_out), 32'd0);
        oe_n = 1'b0; #1;
        chk("R7 oe low again", 32'(dq_drive), 32'd1);
        chk("R7 data again", 32'(dq_out), 32'(ref_mem[12]));

        // R9: sleep ignores a write start.
        sleep = 1'b1; adsc_n = 1'b0; addr = 6'd9; gw_n = 1'b0; wdata = ~ref_mem[9];
        #1;
        chk("R9 dark during sleep", 32'(dq_drive), 32'd0);
        tick();
        set_idle();
        #1;
        chk("R9 dark after sleep", 32'(dq_drive), 32'd0);
        rd_adsp(9, "R9 memory untouched");

        // R10: deselect, then a continue write must do nothing.
        rd_adsp(5, "R10 start");
        ce2 = 1'b0; adsp_n = 1'b0; addr = 6'd5;
        tick();
        set_idle();
        #1;
        chk("R10 dark after deselect", 32'(dq_drive), 32'd0);
        adv_n = 1'b0; gw_n = 1'b0; wdata = ~ref_mem[6];
        tick();
        set_idle();
        #1;
        chk("R10 no read when inactive", 32'(dq_drive), 32'd0);
        ce3_n = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 6'd5; wdata = ~ref_mem[5];
        tick();
        set_idle();
        #1;
        chk("R10 ce3 deselect dark", 32'(dq_drive), 32'd0);
        rd_adsp(5, "R10 word 5 untouched");
        rd_adsp(6, "R10 word 6 untouched");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule